// File: doc/BRIEF.md
# Twelve-Pin GPIO Port with Interrupt Detection

This block is a general-purpose I/O port of twelve pins behind a small memory-mapped register interface. Software sets an output latch and a per-pin direction; for pins set as inputs, the port reads back the pin level after a two-flop synchronizer. For pins set as outputs, it reads back the latch.

Each pin also has an interrupt detector. Three configuration bits pick the trigger: a sense bit chooses edge or level detection; a both-edges bit makes any transition fire; and a polarity bit picks rising/high or falling/low. Edge events are held in a per-pin latch until a write-one-to-clear. Level events follow the pin and are not held. Raw and masked status can be read. The OR of all masked bits drives one interrupt line through a two-stage synchronizer.

The bus has a single cycle. A write takes effect at the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr` and the current state.

Top module: `gpio_irq_port`

## Requirements
- R1: After a synchronous active-high reset, every register reads zero, `pin_oe` and `pin_out` are zero and `irq` is low.
- R2: A write to offset 0x3FFC loads the output latch driven on `pin_out`. A write to 0x8000 sets the direction, and it is driven on `pin_oe` (bit = 1 means output).
- R3: A read of 0x3FFC returns the latch for output pins and the input level for input pins. An input change becomes visible two clock edges after it is applied.
- R4: With sense bit (0x8004) = 0 and both-edges bit (0x8008) = 0, polarity bit (0x800C) = 1 latches a rising edge and polarity bit = 0 latches a falling edge in raw status (0x8014).
- R5: With sense = 0 and both-edges = 1, both rising and falling edges latch, whatever the polarity bit is.
- R6: With sense = 1, raw status follows whether the synchronized level equals the polarity bit. It is not latched, and a clear write leaves it set while the level holds.
- R7: Masked status (0x8018) equals raw status AND the mask register (0x8010, bit = 1 enables).
- R8: Writing 1 to a bit of 0x801C clears that pin's edge latch. Writing 0 leaves the latch unchanged.
- R9: When a new edge and a clear of the same pin land on the same clock edge, the latch stays set.
- R10: `irq` equals the OR of masked status, delayed by exactly two clock cycles.
- R11: Bits 31..12 of every register read zero, and reads of 0x801C return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 12 | Pin levels from the pads |
| pin_out | output | 12 | Output latch to the pads |
| pin_oe | output | 12 | Per-pin output enable |
| irq | output | 1 | Combined interrupt after two-stage synchronizer |

## Verification
Directed cases place rising and falling edges on pins whose polarity bits differ, so a swapped polarity shows up as a wrong bit. A level-mode pin gets a clear write while it is held active, which separates a level that follows the pin from one that is wrongly latched. A clear is aimed at the exact edge where a new edge is latched, and then one cycle later, which tells the edge-wins priority apart from clear-wins. Random trials draw the configuration and pin transitions, so that sense, both-edges, polarity and mask are tried in every combination. The bench samples `irq` cycle by cycle to pin down its two-cycle lag.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int NPINS  = 12;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    localparam logic [15:0] A_DATA  = 16'h3FFC;
    localparam logic [15:0] A_DIR   = 16'h8000;
    localparam logic [15:0] A_SENSE = 16'h8004;
    localparam logic [15:0] A_BOTH  = 16'h8008;
    localparam logic [15:0] A_POL   = 16'h800C;
    localparam logic [15:0] A_MASK  = 16'h8010;
    localparam logic [15:0] A_RAW   = 16'h8014;
    localparam logic [15:0] A_MIS   = 16'h8018;
    localparam logic [15:0] A_CLR   = 16'h801C;

    // per-pin trigger configuration
    typedef struct packed {
        logic sense;   // 1 = level
        logic both;    // 1 = any transition
        logic pol;     // 1 = rising/high
    } trig_cfg_t;

    function automatic logic edge_fire(input logic cur, input logic prev, input trig_cfg_t c);
        logic rise, fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        if (c.both) return rise | fall;
        return c.pol ? rise : fall;
    endfunction

    function automatic logic level_fire(input logic cur, input trig_cfg_t c);
        return cur == c.pol;
    endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [N-1:0] s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= '0;
            dout <= '0;
        end else begin
            s1   <= din;
            dout <= s1;
        end
    end

    // cycles since reset, saturating, for the delay check
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst) age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    // R3 / R10: output lags input by exactly two edges
    p_two_stage_r3: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
    import gpio_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cur,
    input  logic      prev,
    input  trig_cfg_t cfg,
    input  logic      clr,
    output logic      raw
);
    logic hit;
    logic lat;

    assign hit = ~cfg.sense & edge_fire(cur, prev, cfg);

    always_ff @(posedge clk) begin
        if (rst)      lat <= 1'b0;
        else if (hit) lat <= 1'b1;   // new edge beats clear
        else if (clr) lat <= 1'b0;
    end

    assign raw = cfg.sense ? level_fire(cur, cfg) : lat;

    p_edge_wins_r9: assert property (@(posedge clk) disable iff (rst)
        hit |=> lat);
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit) |=> !lat);
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!clr && !hit && lat) |=> lat);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int N  = NPINS,
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [N-1:0]  pin_in,
    output logic [N-1:0]  pin_out,
    output logic [N-1:0]  pin_oe,
    output logic          irq
);
    localparam int PAD = DW - N;

    logic [N-1:0] out_q, dir_q, sense_q, both_q, pol_q, mask_q;
    logic [N-1:0] pin_s, pin_p, raw, masked, clr_vec, wlo;
    logic         irq_any;

    assign wlo = bus_wdata[N-1:0];

    function automatic logic hit_addr(input logic [AW-1:0] a, input logic [15:0] off);
        return a == AW'(off);
    endfunction

    // register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q   <= '0;
            dir_q   <= '0;
            sense_q <= '0;
            both_q  <= '0;
            pol_q   <= '0;
            mask_q  <= '0;
        end else if (bus_we) begin
            if (hit_addr(bus_addr, A_DATA))  out_q   <= wlo;
            if (hit_addr(bus_addr, A_DIR))   dir_q   <= wlo;
            if (hit_addr(bus_addr, A_SENSE)) sense_q <= wlo;
            if (hit_addr(bus_addr, A_BOTH))  both_q  <= wlo;
            if (hit_addr(bus_addr, A_POL))   pol_q   <= wlo;
            if (hit_addr(bus_addr, A_MASK))  mask_q  <= wlo;
        end
    end

    assign clr_vec = (bus_we && hit_addr(bus_addr, A_CLR)) ? wlo : '0;

    // input synchronizer and previous sample
    gpio_in_sync #(.N(N)) u_pin_sync (
        .clk (clk),
        .rst (rst),
        .din (pin_in),
        .dout(pin_s)
    );

    always_ff @(posedge clk) begin
        if (rst) pin_p <= '0;
        else     pin_p <= pin_s;
    end

    // per-pin detectors
    for (genvar i = 0; i < N; i++) begin : g_cell
        trig_cfg_t cfg_i;
        assign cfg_i = '{sense: sense_q[i], both: both_q[i], pol: pol_q[i]};
        gpio_irq_cell u_cell (
            .clk (clk),
            .rst (rst),
            .cur (pin_s[i]),
            .prev(pin_p[i]),
            .cfg (cfg_i),
            .clr (clr_vec[i]),
            .raw (raw[i])
        );
    end

    assign masked  = raw & mask_q;
    assign irq_any = |masked;

    gpio_in_sync #(.N(1)) u_irq_sync (
        .clk (clk),
        .rst (rst),
        .din (irq_any),
        .dout(irq)
    );

    assign pin_out = out_q;
    assign pin_oe  = dir_q;

    // read mux
    logic [N-1:0] rd_lo;
    always_comb begin
        rd_lo = '0;
        if (hit_addr(bus_addr, A_DATA))  rd_lo = (out_q & dir_q) | (pin_s & ~dir_q);
        if (hit_addr(bus_addr, A_DIR))   rd_lo = dir_q;
        if (hit_addr(bus_addr, A_SENSE)) rd_lo = sense_q;
        if (hit_addr(bus_addr, A_BOTH))  rd_lo = both_q;
        if (hit_addr(bus_addr, A_POL))   rd_lo = pol_q;
        if (hit_addr(bus_addr, A_MASK))  rd_lo = mask_q;
        if (hit_addr(bus_addr, A_RAW))   rd_lo = raw;
        if (hit_addr(bus_addr, A_MIS))   rd_lo = masked;
    end
    assign bus_rdata = {{PAD{1'b0}}, rd_lo};

    p_oe_follow_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && hit_addr(bus_addr, A_DIR)) |=> (pin_oe == $past(wlo)));
    p_irq_lag_r10: assert property (@(posedge clk) disable iff (rst)
        irq == $past(irq_any, 2));
    p_clr_reads_zero_r11: assert property (@(posedge clk) disable iff (rst)
        hit_addr(bus_addr, A_CLR) |-> (bus_rdata == '0));
    p_mask_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |=> !irq_any || (mask_q != '0));
endmodule

// File: tb/gpio_irq_port_bench.sv
`timescale 1ns/1ps
module gpio_irq_port_bench;
    localparam int N = 12;
    localparam logic [31:0] LOWM = 32'h0000_0FFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out, pin_oe;
    logic        irq;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    gpio_irq_port u_gpio_irq_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d cycles expected below 150000", cycles);
            summary();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [N-1:0] exp_raw(input logic [N-1:0] sen, input logic [N-1:0] bth,
                                             input logic [N-1:0] pol, input logic [N-1:0] op,
                                             input logic [N-1:0] np);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            if (sen[i])      r[i] = (np[i] == pol[i]);
            else if (bth[i]) r[i] = (op[i] != np[i]);
            else if (pol[i]) r[i] = ~op[i] & np[i];
            else             r[i] = op[i] & ~np[i];
        end
        return r;
    endfunction

    logic [31:0] v;

    initial begin
        void'($urandom(32'd2024));
        cyc(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        foreach (u_rd_list[k]) begin end
        rd(16'h3FFC, v); chk("R1 data", v, 0);
        rd(16'h8000, v); chk("R1 dir", v, 0);
        rd(16'h8004, v); chk("R1 sense", v, 0);
        rd(16'h8008, v); chk("R1 both", v, 0);
        rd(16'h800C, v); chk("R1 pol", v, 0);
        rd(16'h8010, v); chk("R1 mask", v, 0);
        rd(16'h8014, v); chk("R1 raw", v, 0);
        chk("R1 pin_oe", {20'd0, pin_oe}, 0);
        chk("R1 pin_out", {20'd0, pin_out}, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2 direction and output latch
        wr(16'h8000, 32'h0F0);
        wr(16'h3FFC, 32'hA5A);
        chk("R2 pin_oe", {20'd0, pin_oe}, 32'h0F0);
        chk("R2 pin_out", {20'd0, pin_out}, 32'hA5A);

        // R3 readback mix and two-edge latency
        pin_in = 12'h3C3;
        cyc(3);
        rd(16'h3FFC, v); chk("R3 mixed read", v, ((32'hA5A & 32'h0F0) | (32'h3C3 & ~32'h0F0)) & LOWM);
        pin_in = 12'h000;
        cyc(1);
        rd(16'h3FFC, v); chk("R3 after one edge", v, ((32'hA5A & 32'h0F0) | (32'h3C3 & ~32'h0F0)) & LOWM);
        cyc(1);
        rd(16'h3FFC, v); chk("R3 after two edges", v, 32'hA5A & 32'h0F0);
        wr(16'h8000, 32'h0);
        wr(16'h3FFC, 32'h0);

        // R11 reserved bits and write-only clear
        wr(16'h8010, 32'hFFFF_FFFF);
        rd(16'h8010, v); chk("R11 reserved", v, LOWM);
        wr(16'h8010, 32'h0);
        rd(16'h801C, v); chk("R11 clear reads zero", v, 0);

        // R4 single-polarity edges: pin0 rising, pin1 falling
        wr(16'h800C, 32'h001);
        wr(16'h801C, LOWM);
        pin_in = 12'h003; cyc(4);
        rd(16'h8014, v); chk("R4 rise latched", v, 32'h001);
        pin_in = 12'h000; cyc(4);
        rd(16'h8014, v); chk("R4 fall latched", v, 32'h003);

        // R8 clear one, zero write no effect
        wr(16'h801C, 32'h002);
        rd(16'h8014, v); chk("R8 clear bit1", v, 32'h001);
        wr(16'h801C, 32'h000);
        rd(16'h8014, v); chk("R8 zero no effect", v, 32'h001);

        // R7 / R10 mask and irq lag
        cyc(3);
        chk("R10 masked irq low", {31'd0, irq}, 0);
        wr(16'h8010, 32'h001);
        rd(16'h8018, v); chk("R7 masked", v, 32'h001);
        chk("R10 lag0", {31'd0, irq}, 0);
        cyc(1); chk("R10 lag1", {31'd0, irq}, 0);
        cyc(1); chk("R10 lag2", {31'd0, irq}, 1);
        wr(16'h801C, LOWM);
        cyc(3); chk("R10 irq drops", {31'd0, irq}, 0);
        wr(16'h8010, 32'h0);

        // R9 clear on the latching edge
        pin_in = 12'h001;      // pin0 rising, pol=1
        @(negedge clk);        // edge k
        @(negedge clk);        // edge k+1
        bus_addr = 16'h801C; bus_wdata = 32'h001; bus_we = 1'b1;
        @(negedge clk);        // edge k+2: latch and clear together
        bus_we = 1'b0;
        rd(16'h8014, v); chk("R9 edge wins", v, 32'h001);
        wr(16'h801C, 32'h001);
        rd(16'h8014, v); chk("R9 later clear", v, 32'h000);
        pin_in = 12'h000; cyc(4);
        wr(16'h801C, LOWM);

        // R6 level mode on pin4, high active
        wr(16'h8004, 32'h010);
        wr(16'h800C, 32'h010);
        rd(16'h8014, v); chk("R6 level idle", v, 32'h000);
        pin_in = 12'h010; cyc(3);
        rd(16'h8014, v); chk("R6 level set", v, 32'h010);
        wr(16'h801C, 32'h010);
        rd(16'h8014, v); chk("R6 clear no hold", v, 32'h010);
        pin_in = 12'h000; cyc(3);
        rd(16'h8014, v); chk("R6 level follows", v, 32'h000);
        wr(16'h8004, 32'h0);

        // R5 both edges on pin2 with pol 0
        wr(16'h800C, 32'h0);
        wr(16'h8008, 32'h004);
        wr(16'h801C, LOWM);
        pin_in = 12'h004; cyc(4);
        rd(16'h8014, v); chk("R5 rise with both", v, 32'h004);
        wr(16'h801C, LOWM);
        pin_in = 12'h000; cyc(4);
        rd(16'h8014, v); chk("R5 fall with both", v, 32'h004);
        wr(16'h8008, 32'h0);

        // random trials over R4 R5 R6 R7 R10
        for (int t = 0; t < 60; t++) begin
            logic [N-1:0] sen, bth, pol, msk, op, np, er;
            sen = N'($urandom); bth = N'($urandom); pol = N'($urandom);
            msk = N'($urandom); op = N'($urandom); np = N'($urandom);
            pin_in = op;
            wr(16'h8004, {20'd0, sen});
            wr(16'h8008, {20'd0, bth});
            wr(16'h800C, {20'd0, pol});
            wr(16'h8010, {20'd0, msk});
            cyc(4);
            wr(16'h801C, LOWM);
            pin_in = np;
            cyc(5);
            er = exp_raw(sen, bth, pol, op, np);
            rd(16'h8014, v); chk("R4 R5 R6 random raw", v, {20'd0, er});
            rd(16'h8018, v); chk("R7 random masked", v, {20'd0, er & msk});
            chk("R10 random irq", {31'd0, irq}, {31'd0, |(er & msk)});
        end

        summary();
    end

    int u_rd_list[1];
endmodule